// File: doc/BRIEF.md
# Cascadable Fall-Through FIFO Chain

This block is a single-clock FIFO whose oldest stored word is presented at the read side without any read request. Presence is signalled by an active-low flag. A second active-low flag on the write side reports that a free location exists. The flags are built so that identical stages connect head to tail with no glue. Each stage takes its upstream neighbour's data output as write data and that neighbour's output-present flag as its active-low write enable. Its own room flag serves as the upstream neighbour's active-low read enable. Words therefore ripple forward and free locations bubble backward by themselves.

The top module instantiates `STAGES` such stages in series. Each stage stores `DEPTH` words in a memory plus one word in a look-ahead output register. Pointer updates reach the opposite side of a stage through a two-register lag. This lag fixes the first-word and first-free-slot latencies. Once data is flowing, it still lets the chain move one word per clock.

Both edges use a valid/ready rule. On the write side, a word is taken on a rising edge when the write enable is low and the room flag is low. A write offered while the room flag is high is dropped, and the source must hold it and retry. On the read side, the word on `rd_data` is consumed on a rising edge when the present flag is low and the read enable is low. Until it is consumed, it stays unchanged.

Top module: `fwft_cascade`

## Requirements
- R1: After reset, `out_avail_n` is 1 (nothing to read) and `in_room_n` is 0 (room available), and the chain holds no words.
- R2: A word pushed into an empty stage drives `out_avail_n` low after the 3rd rising edge following its push edge, with no read issued. Through an empty chain of N stages, this latency is 4*(N-1)+3 edges.
- R3: A pop from a full stage drives its `in_room_n` low after the 2nd rising edge following the pop edge. Through a full chain of N stages, the top `in_room_n` goes low 3*(N-1)+2 edges after the pop.
- R4: Words leave in the order they were accepted, each exactly once. While `out_avail_n` is 0 and no pop is taken, `rd_data` and `out_avail_n` hold.
- R5: A push offered while `in_room_n` is 1 is ignored and stores nothing.
- R6: A pop offered while `out_avail_n` is 1 is ignored and discards nothing.
- R7: Each stage holds DEPTH+1 words, and the chain holds STAGES*(DEPTH+1). A filled chain keeps `in_room_n` at 1.
- R8: With DEPTH of at least 8 and the read side always popping, a push is accepted on every clock. After the first word arrives, one word leaves on every clock of the burst.
- R9: A push and a pop taken in the same cycle are both accepted, so the count of stored words is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for all stages |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | WIDTH | Word offered to the first stage |
| wr_en_n | input | 1 | Active-low push request |
| in_room_n | output | 1 | Active-low: first stage has a free location |
| rd_en_n | input | 1 | Active-low pop request at the last stage |
| rd_data | output | WIDTH | Word presented by the last stage |
| out_avail_n | output | 1 | Active-low: `rd_data` holds a valid word |

## Verification
The bench builds a chain of three stages, each with DEPTH 8 and a WIDTH of 16. Three stages make every intermediate hop visible in the measured first-word latency (11 edges) and in the measured free-slot latency (8 edges). DEPTH 8 is the smallest power of two that lets the two-register pointer lag sustain one word per clock. This makes the back-to-back streaming check meaningful. The chain capacity of 27 is small enough that filling it, probing a refused push, and draining it again take few cycles next to a long random push/pop run.

// File: rtl/fwft_pkg.sv
package fwft_pkg;
  // Number of registers a pointer crosses before the opposite side sees it.
  localparam int unsigned PTR_LAG = 2;

  // Active-low handshake flag encoding.
  typedef enum logic {
    FLAG_ON  = 1'b0,
    FLAG_OFF = 1'b1
  } flag_n_t;
endpackage

// File: rtl/fwft_lag.sv
module fwft_lag #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/fwft_store.sv
module fwft_store #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_req,
  input  logic [PW-1:0]    rd_ptr,
  input  logic [PW-1:0]    rd_ptr_seen,
  output logic [PW-1:0]    wr_ptr,
  output logic             full,
  output logic [WIDTH-1:0] head_word
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic             take;

  // Occupancy judged against the lagged read pointer: never under-reports.
  assign full      = (wr_ptr - rd_ptr_seen) == DEPTH_P;
  assign take      = wr_req && !full;
  assign head_word = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (take) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    wr_ptr <= '0;
    else if (take) wr_ptr <= wr_ptr + PW'(1);
  end

  // R5: a refused push leaves the write pointer where it was
  a_r5_full_drops_push: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full) |=> (wr_ptr == $past(wr_ptr)));

  // R7: the memory never holds more than DEPTH unread words
  a_r7_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(wr_ptr - rd_ptr) <= DEPTH_P);
endmodule

// File: rtl/fwft_head.sv
module fwft_head
  import fwft_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned PW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en_n,
  input  logic [PW-1:0]    wr_ptr_seen,
  input  logic [WIDTH-1:0] head_word,
  output logic [PW-1:0]    rd_ptr,
  output logic [WIDTH-1:0] rd_data,
  output logic             out_avail_n
);
  logic    valid;
  logic    stored;
  logic    pop;
  logic    load;
  flag_n_t flag;

  assign stored = (wr_ptr_seen != rd_ptr);
  assign pop    = valid && !rd_en_n;
  assign load   = stored && (!valid || pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      rd_ptr  <= '0;
      rd_data <= '0;
    end else if (load) begin
      valid   <= 1'b1;
      rd_ptr  <= rd_ptr + PW'(1);
      rd_data <= head_word;
    end else if (pop) begin
      valid   <= 1'b0;
    end
  end

  assign flag        = valid ? FLAG_ON : FLAG_OFF;
  assign out_avail_n = flag;

  // R4: a presented word stays put until it is popped
  a_r4_hold_until_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_avail_n && rd_en_n) |=> (!out_avail_n && $stable(rd_data)));
endmodule

// File: rtl/fwft_stage.sv
module fwft_stage
  import fwft_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_en_n,
  output logic             in_room_n,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             out_avail_n
);
  logic [PW-1:0]    wr_ptr, rd_ptr, wr_ptr_seen, rd_ptr_seen;
  logic [WIDTH-1:0] head_word;
  logic             full;

  fwft_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_req(!wr_en_n),
    .rd_ptr(rd_ptr), .rd_ptr_seen(rd_ptr_seen), .wr_ptr(wr_ptr),
    .full(full), .head_word(head_word)
  );

  // Write pointer travels to the read side (sets fall-through latency).
  fwft_lag #(.W(PW), .STAGES(PTR_LAG)) wlag_i (
    .clk(clk), .rst_n(rst_n), .d(wr_ptr), .q(wr_ptr_seen)
  );

  // Read pointer travels to the write side (sets bubble-up latency).
  fwft_lag #(.W(PW), .STAGES(PTR_LAG)) rlag_i (
    .clk(clk), .rst_n(rst_n), .d(rd_ptr), .q(rd_ptr_seen)
  );

  fwft_head #(.WIDTH(WIDTH), .PW(PW)) head_i (
    .clk(clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .wr_ptr_seen(wr_ptr_seen),
    .head_word(head_word), .rd_ptr(rd_ptr), .rd_data(rd_data),
    .out_avail_n(out_avail_n)
  );

  assign in_room_n = full;

  // R2: a word visible to the read side fills an empty output on the next edge
  a_r2_fall_through_load: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_ptr_seen != rd_ptr) && out_avail_n) |=> !out_avail_n);
endmodule

// File: rtl/fwft_cascade.sv
module fwft_cascade #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned STAGES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_en_n,
  output logic             in_room_n,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             out_avail_n
);
  logic [STAGES:0][WIDTH-1:0] link_data;
  logic [STAGES:0]            link_avail_n;
  logic [STAGES:0]            link_room_n;

  assign link_data[0]         = wr_data;
  assign link_avail_n[0]      = wr_en_n;
  assign link_room_n[STAGES]  = rd_en_n;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    fwft_stage #(.WIDTH(WIDTH), .DEPTH(DEPTH)) stage_i (
      .clk(clk), .rst_n(rst_n),
      .wr_data(link_data[s]), .wr_en_n(link_avail_n[s]),
      .in_room_n(link_room_n[s]),
      .rd_en_n(link_room_n[s+1]),
      .rd_data(link_data[s+1]), .out_avail_n(link_avail_n[s+1])
    );
  end

  assign in_room_n   = link_room_n[0];
  assign rd_data     = link_data[STAGES];
  assign out_avail_n = link_avail_n[STAGES];
endmodule

// File: tb/fwft_cascade_tb_top.sv
module fwft_cascade_tb_top;
  localparam int WIDTH  = 16;
  localparam int DEPTH  = 8;
  localparam int STAGES = 3;
  localparam int CAP    = STAGES * (DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             wr_en_n = 1'b1;
  logic             rd_en_n = 1'b1;
  logic             in_room_n;
  logic [WIDTH-1:0] rd_data;
  logic             out_avail_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [WIDTH-1:0] model_q [$];
  logic [WIDTH-1:0] seq = 16'h0100;
  logic s_out_n, s_room_n;

  always #10 clk = ~clk;

  fwft_cascade #(.WIDTH(WIDTH), .DEPTH(DEPTH), .STAGES(STAGES)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en_n(wr_en_n),
    .in_room_n(in_room_n), .rd_en_n(rd_en_n), .rd_data(rd_data),
    .out_avail_n(out_avail_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model, updated mid-cycle from the values the next edge samples.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!out_avail_n) begin
        chk(model_q.size() > 0, "R4 word presented from empty model", 1, 0);
        if (model_q.size() > 0)
          chk(rd_data == model_q[0], "R4 output order", int'(rd_data), int'(model_q[0]));
      end
      if (model_q.size() == 0)
        chk(out_avail_n == 1'b1, "R6 empty chain shows no word", int'(out_avail_n), 1);
      if (!rd_en_n && !out_avail_n && model_q.size() > 0) void'(model_q.pop_front());
      if (!wr_en_n && !in_room_n) model_q.push_back(wr_data);
      chk(model_q.size() <= CAP, "R7 stored words within capacity", model_q.size(), CAP);
    end
  end

  // One clock: drive, sample mid-cycle, pass the edge.
  task automatic step(input bit w, input bit r);
    bit acc;
    wr_en_n = ~w;
    rd_en_n = ~r;
    wr_data = seq;
    @(negedge clk);
    s_out_n  = out_avail_n;
    s_room_n = in_room_n;
    acc = w && !in_room_n;
    @(posedge clk);
    #2;
    if (acc) seq = seq + 16'd1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int lat, run, best, pushed;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(out_avail_n == 1'b1, "R1 out_avail_n after reset", int'(out_avail_n), 1);
    chk(in_room_n == 1'b0, "R1 in_room_n after reset", int'(in_room_n), 0);
    @(posedge clk); #2;

    // R6: pops into an empty chain are ignored
    for (int i = 0; i < 6; i++) step(0, 1);
    chk(s_out_n == 1'b1, "R6 still empty after idle pops", int'(s_out_n), 1);

    // R2: first word ripples down with no read issued
    step(1, 0);
    lat = -1;
    for (int k = 0; k < 40; k++) begin
      step(0, 0);
      if (lat < 0 && !s_out_n) lat = k;
    end
    chk(lat == 4*(STAGES-1)+3, "R2 first-word latency", lat, 4*(STAGES-1)+3);
    for (int i = 0; i < 4; i++) step(0, 1);
    chk(s_out_n == 1'b1, "R6 chain empty after single word", int'(s_out_n), 1);

    // R7: fill until refusal is stable
    run = 0;
    for (int i = 0; i < 400 && run < 20; i++) begin
      step(1, 0);
      run = s_room_n ? run + 1 : 0;
    end
    chk(model_q.size() == CAP, "R7 chain capacity", model_q.size(), CAP);
    chk(s_room_n == 1'b1, "R7 full chain refuses", int'(s_room_n), 1);

    // R5: keep offering while full; nothing may enter
    for (int i = 0; i < 5; i++) step(1, 0);
    chk(model_q.size() == CAP, "R5 refused pushes stored nothing", model_q.size(), CAP);

    // R3: one pop from the full chain, free slot bubbles up
    step(0, 1);
    lat = -1;
    for (int k = 0; k < 40; k++) begin
      step(0, 0);
      if (lat < 0 && !s_room_n) lat = k;
    end
    chk(lat == 3*(STAGES-1)+2, "R3 free-slot latency", lat, 3*(STAGES-1)+2);

    // drain
    for (int i = 0; i < 120; i++) step(0, 1);
    chk(model_q.size() == 0 && s_out_n, "R4 drained after fill", model_q.size(), 0);

    // R8 / R9: back-to-back burst with continuous popping
    pushed = 0;
    run = 0; best = 0;
    for (int i = 0; i < 40; i++) begin
      step(1, 1);
      if (!s_room_n) pushed++;
      run = !s_out_n ? run + 1 : 0;
      if (run > best) best = run;
    end
    for (int i = 0; i < 30; i++) begin
      step(0, 1);
      run = !s_out_n ? run + 1 : 0;
      if (run > best) best = run;
    end
    chk(pushed == 40, "R8 every burst push accepted", pushed, 40);
    chk(best == 40, "R8 one word per clock at output", best, 40);
    chk(model_q.size() == 0, "R9 burst fully delivered", model_q.size(), 0);

    // random traffic, model compares every clock
    for (int i = 0; i < 3000; i++) step(($urandom % 3) != 0, ($urandom % 2) != 0);
    for (int i = 0; i < 150; i++) step(0, 1);
    chk(model_q.size() == 0, "R4 random traffic drained", model_q.size(), 0);
    chk(s_out_n == 1'b1, "R6 idle after drain", int'(s_out_n), 1);
    chk(s_room_n == 1'b0, "R1 room restored after drain", int'(s_room_n), 0);
    finish_run();
  end
endmodule